// File: doc/BRIEF.md
# Indexed ADC Result Buffer with Data-Available Interrupt

This block keeps the most recent conversion results of an analog front end in a small slot buffer and hands them to a processor through one data port. Each finished conversion goes to a slot in one of two ways. By default the slot number is the conversion's channel number. When redirection is turned on, every result goes to a single alternate slot that software chose earlier.

The data port has two meanings, chosen by a configuration-mode input. In configuration mode, a write to the port sets the alternate slot and a read returns it. In normal mode, a read returns the slot under a read index, and the index then steps forward by one. The index wraps to slot 0 after the last slot. Software can also load the index directly.

A sticky data-available flag is set at the end of every conversion sequence. In count mode it is also set after every NUM_SMP+1 conversions. An interrupt request is raised while the flag is set and the interrupt is enabled. Software clears the flag by writing 1 to its clear input.

Top module: `adc_result_buf`

## Requirements
- R1: After reset, data_flag, irq and rd_idx are 0, every slot reads as 0, and the alternate slot is 0.
- R2: With ovr_en=0, a conversion on channel c with c < NUM_SLOTS (25) writes its data to slot c. A conversion with c >= 25 changes no slot.
- R3: With ovr_en=1, a conversion writes its data to the alternate slot, whatever its channel. If the alternate slot is 25 or more, no slot changes.
- R4: In normal mode (cfg_mode=0), port_rdata equals the content of slot rd_idx, and a port_rd pulse moves rd_idx up by one on the next cycle.
- R5: A normal-mode read at rd_idx = 24 moves rd_idx back to 0.
- R6: With cfg_mode=1, port_wr loads port_wdata into the alternate slot, port_rdata returns the alternate slot zero-extended, and port_rd leaves rd_idx unchanged. With cfg_mode=0, port_wr changes neither the alternate slot nor any buffer slot.
- R7: idx_load sets rd_idx to idx_val on the next cycle, or to 0 if idx_val is 25 or more. idx_load takes priority over port_rd in the same cycle.
- R8: A seq_end pulse sets data_flag on the next cycle. irq is 1 exactly when data_flag=1 and int_en=1.
- R9: With cnt_mode=1, the conversion that completes NUM_SMP+1 conversions, counted since the last sequence start or the last count-triggered set, sets data_flag on the next cycle. With cnt_mode=0, conversions never set the flag.
- R10: flag_clr clears data_flag on the next cycle. If a set event happens in the same cycle, the set wins and the flag stays 1.
- R11: seq_start clears the conversion count. A conversion in the same cycle as seq_start is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_valid | input | 1 | A conversion result is present this cycle |
| conv_chan | input | 5 | Channel number of the result |
| conv_data | input | DATA_W | Conversion result |
| seq_start | input | 1 | Start of a conversion sequence |
| seq_end | input | 1 | End of a conversion sequence |
| cfg_mode | input | 1 | Selects configuration meaning of the data port |
| ovr_en | input | 1 | Redirect every result to the alternate slot |
| port_wr | input | 1 | Data port write strobe |
| port_wdata | input | 5 | Data port write value (the alternate slot) |
| port_rd | input | 1 | Data port read strobe |
| port_rdata | output | DATA_W | Data port read value |
| idx_load | input | 1 | Load the read index |
| idx_val | input | 5 | Value for the read index |
| rd_idx | output | 5 | Current read index |
| cnt_mode | input | 1 | Also set the flag every NUM_SMP+1 conversions |
| num_smp | input | CNT_W | Conversion count minus one for the count trigger |
| int_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Clear the data-available flag |
| data_flag | output | 1 | Sticky data-available flag |
| irq | output | 1 | Interrupt request |

## Verification
The count trigger is the hardest behaviour to reach from the ports. The conversion counter is never visible, so its value has to be inferred from the cycle in which the flag rises. The bench sweeps num_smp over several small values. For each value it starts a sequence, feeds conversions one at a time, and checks the flag after every conversion: the flag must stay low until the (num_smp+1)-th conversion and must be high after it. It then clears the flag and repeats the run to show that the counter restarted. A separate run puts a conversion in the same cycle as seq_start, which moves the expected trigger point by one conversion.

// File: rtl/adc_buf_pkg.sv
package adc_buf_pkg;
    localparam int IDX_W = 5;
    typedef logic [IDX_W-1:0] slot_idx_t;
endpackage

// File: rtl/abuf_wr_route.sv
module abuf_wr_route
    import adc_buf_pkg::*;
#(
    parameter int NUM_SLOTS = 25
) (
    input  logic      conv_valid,
    input  slot_idx_t conv_chan,
    input  logic      ovr_en,
    input  slot_idx_t alt_loc,
    output logic      we,
    output slot_idx_t waddr
);
    localparam slot_idx_t LAST = slot_idx_t'(NUM_SLOTS - 1);

    always_comb begin
        waddr = ovr_en ? alt_loc : conv_chan;
        we    = conv_valid && (waddr <= LAST);
    end
endmodule

// File: rtl/abuf_store.sv
module abuf_store
    import adc_buf_pkg::*;
#(
    parameter int NUM_SLOTS = 25,
    parameter int DATA_W    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  slot_idx_t         waddr,
    input  logic [DATA_W-1:0] wdata,
    input  slot_idx_t         raddr,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        logic [NUM_SLOTS-1:0][DATA_W-1:0] mem;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (we && (waddr == slot_idx_t'(i))) begin
                st_d.mem[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (raddr == slot_idx_t'(i)) begin
                rdata = st_q.mem[i];
            end
        end
    end
endmodule

// File: rtl/abuf_rd_ptr.sv
module abuf_rd_ptr
    import adc_buf_pkg::*;
#(
    parameter int NUM_SLOTS = 25
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      adv,
    input  logic      load,
    input  slot_idx_t load_val,
    output slot_idx_t idx
);
    localparam slot_idx_t LAST = slot_idx_t'(NUM_SLOTS - 1);

    typedef struct packed {
        slot_idx_t idx;
    } ptr_t;

    ptr_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (load) begin
            p_d.idx = (load_val > LAST) ? '0 : load_val;
        end else if (adv) begin
            p_d.idx = (p_q.idx == LAST) ? '0 : p_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign idx = p_q.idx;
endmodule

// File: rtl/abuf_flag.sv
module abuf_flag #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv,
    input  logic             seq_start,
    input  logic             seq_end,
    input  logic             cnt_mode,
    input  logic [CNT_W-1:0] num_smp,
    input  logic             clr,
    output logic             flag
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flag;
    } flag_t;

    flag_t f_d, f_q;
    logic  reached;
    logic  hit;

    always_comb begin
        f_d     = f_q;
        reached = conv && !seq_start && (f_q.cnt == num_smp);
        hit     = reached && cnt_mode;
        if (seq_start || reached) begin
            f_d.cnt = '0;
        end else if (conv) begin
            f_d.cnt = f_q.cnt + 1'b1;
        end
        if (seq_end || hit) begin
            f_d.flag = 1'b1;
        end else if (clr) begin
            f_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign flag = f_q.flag;
endmodule

// File: rtl/adc_result_buf.sv
module adc_result_buf
    import adc_buf_pkg::*;
#(
    parameter int NUM_SLOTS = 25,
    parameter int DATA_W    = 12,
    parameter int CNT_W     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_valid,
    input  logic [4:0]        conv_chan,
    input  logic [DATA_W-1:0] conv_data,
    input  logic              seq_start,
    input  logic              seq_end,
    input  logic              cfg_mode,
    input  logic              ovr_en,
    input  logic              port_wr,
    input  logic [4:0]        port_wdata,
    input  logic              port_rd,
    output logic [DATA_W-1:0] port_rdata,
    input  logic              idx_load,
    input  logic [4:0]        idx_val,
    output logic [4:0]        rd_idx,
    input  logic              cnt_mode,
    input  logic [CNT_W-1:0]  num_smp,
    input  logic              int_en,
    input  logic              flag_clr,
    output logic              data_flag,
    output logic              irq
);
    localparam int PAD_W = DATA_W - IDX_W;

    typedef struct packed {
        slot_idx_t alt;
    } cfg_t;

    cfg_t      cfg_d, cfg_q;
    logic      we;
    slot_idx_t waddr;
    logic [DATA_W-1:0] slot_rdata;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_mode && port_wr) begin
            cfg_d.alt = port_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    abuf_wr_route #(.NUM_SLOTS(NUM_SLOTS)) u_route (
        .conv_valid (conv_valid),
        .conv_chan  (conv_chan),
        .ovr_en     (ovr_en),
        .alt_loc    (cfg_q.alt),
        .we         (we),
        .waddr      (waddr)
    );

    abuf_store #(.NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we),
        .waddr (waddr),
        .wdata (conv_data),
        .raddr (rd_idx),
        .rdata (slot_rdata)
    );

    abuf_rd_ptr #(.NUM_SLOTS(NUM_SLOTS)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (port_rd && !cfg_mode),
        .load     (idx_load),
        .load_val (idx_val),
        .idx      (rd_idx)
    );

    abuf_flag #(.CNT_W(CNT_W)) u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .conv      (conv_valid),
        .seq_start (seq_start),
        .seq_end   (seq_end),
        .cnt_mode  (cnt_mode),
        .num_smp   (num_smp),
        .clr       (flag_clr),
        .flag      (data_flag)
    );

    always_comb begin
        port_rdata = cfg_mode ? {{PAD_W{1'b0}}, cfg_q.alt} : slot_rdata;
        irq        = data_flag && int_en;
    end
endmodule

// File: rtl/abuf_chk.sv
module abuf_chk #(
    parameter int NUM_SLOTS = 25
) (
    input logic       clk,
    input logic       rst_n,
    input logic       conv_valid,
    input logic       seq_end,
    input logic       cfg_mode,
    input logic       port_rd,
    input logic       idx_load,
    input logic [4:0] idx_val,
    input logic [4:0] rd_idx,
    input logic       cnt_mode,
    input logic       flag_clr,
    input logic       data_flag
);
    localparam logic [4:0] LAST = 5'(NUM_SLOTS - 1);

    // R8
    seq_end_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_end |=> data_flag);

    // R10
    clear_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr && !seq_end && !conv_valid |=> !data_flag);

    // R9
    flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_flag) |-> ($past(seq_end) || ($past(conv_valid) && $past(cnt_mode))));

    // R4
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_rd && !cfg_mode && !idx_load && (rd_idx != LAST) |=> rd_idx == $past(rd_idx) + 5'd1);

    // R5
    idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_rd && !cfg_mode && !idx_load && (rd_idx == LAST) |=> rd_idx == 5'd0);

    // R6
    cfg_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_rd && cfg_mode && !idx_load |=> $stable(rd_idx));

    // R7
    idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_load |=> rd_idx == (($past(idx_val) > LAST) ? 5'd0 : $past(idx_val)));

    // R7
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_idx <= LAST);
endmodule

bind adc_result_buf abuf_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_valid (conv_valid),
    .seq_end    (seq_end),
    .cfg_mode   (cfg_mode),
    .port_rd    (port_rd),
    .idx_load   (idx_load),
    .idx_val    (idx_val),
    .rd_idx     (rd_idx),
    .cnt_mode   (cnt_mode),
    .flag_clr   (flag_clr),
    .data_flag  (data_flag)
);

// File: tb/sim_adc_result_buf.sv
`timescale 1ns/100ps
module sim_adc_result_buf;
    localparam int NS = 25;
    localparam int DW = 12;
    localparam int CW = 5;

    logic clk = 0;
    logic rst_n = 0;
    logic conv_valid = 0, seq_start = 0, seq_end = 0, cfg_mode = 0, ovr_en = 0;
    logic port_wr = 0, port_rd = 0, idx_load = 0, cnt_mode = 0, int_en = 0, flag_clr = 0;
    logic [4:0] conv_chan = 0, port_wdata = 0, idx_val = 0, rd_idx;
    logic [DW-1:0] conv_data = 0, port_rdata;
    logic [CW-1:0] num_smp = 0;
    logic data_flag, irq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [DW-1:0] exp_mem [NS];

    always #2.5 clk = ~clk;

    adc_result_buf #(.NUM_SLOTS(NS), .DATA_W(DW), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .conv_chan(conv_chan),
        .conv_data(conv_data), .seq_start(seq_start), .seq_end(seq_end),
        .cfg_mode(cfg_mode), .ovr_en(ovr_en), .port_wr(port_wr), .port_wdata(port_wdata),
        .port_rd(port_rd), .port_rdata(port_rdata), .idx_load(idx_load), .idx_val(idx_val),
        .rd_idx(rd_idx), .cnt_mode(cnt_mode), .num_smp(num_smp), .int_en(int_en),
        .flag_clr(flag_clr), .data_flag(data_flag), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic conv(input logic [4:0] ch, input logic [DW-1:0] d);
        conv_valid = 1; conv_chan = ch; conv_data = d;
        tick();
        conv_valid = 0;
    endtask

    task automatic cfg_set_alt(input logic [4:0] a);
        cfg_mode = 1; port_wr = 1; port_wdata = a;
        tick();
        port_wr = 0; cfg_mode = 0;
    endtask

    task automatic load_idx(input logic [4:0] v);
        idx_load = 1; idx_val = v;
        tick();
        idx_load = 0;
    endtask

    // reads all slots from index 0 and compares with the model (R4, R5)
    task automatic sweep_read(input string req);
        load_idx(5'd0);
        for (int i = 0; i < NS; i++) begin
            chk(port_rdata == exp_mem[i], req, int'(port_rdata), int'(exp_mem[i]));
            port_rd = 1;
            tick();
            port_rd = 0;
            chk(rd_idx == 5'((i + 1) % NS), "R4/R5 index step", int'(rd_idx), (i + 1) % NS);
        end
    endtask

    task automatic pulse_clr();
        flag_clr = 1;
        tick();
        flag_clr = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NS; i++) exp_mem[i] = '0;
        tick(); tick();
        rst_n = 1;
        tick();

        // R1 reset state
        chk(data_flag == 0, "R1 flag", int'(data_flag), 0);
        chk(irq == 0, "R1 irq", int'(irq), 0);
        chk(rd_idx == 0, "R1 rd_idx", int'(rd_idx), 0);
        cfg_mode = 1; #0.1;
        chk(port_rdata == 0, "R1 alt slot", int'(port_rdata), 0);
        cfg_mode = 0;
        sweep_read("R1 slot after reset");

        // R2 direct placement, all channel codes
        for (int c = 0; c < 32; c++) begin
            logic [DW-1:0] d;
            d = DW'(c * 97 + 11);
            conv(5'(c), d);
            if (c < NS) exp_mem[c] = d;
        end
        sweep_read("R2 slot by channel");
        chk(rd_idx == 0, "R5 wrap after last", int'(rd_idx), 0);

        // R6 configuration mode port meaning
        load_idx(5'd7);
        cfg_set_alt(5'd19);
        cfg_mode = 1; #0.1;
        chk(port_rdata == 19, "R6 alt readback", int'(port_rdata), 19);
        port_rd = 1;
        tick();
        port_rd = 0;
        chk(rd_idx == 7, "R6 cfg read holds index", int'(rd_idx), 7);
        cfg_mode = 0;
        port_wr = 1; port_wdata = 5'd3;
        tick();
        port_wr = 0;
        cfg_mode = 1; #0.1;
        chk(port_rdata == 19, "R6 normal write ignored", int'(port_rdata), 19);
        cfg_mode = 0;
        sweep_read("R6 slots untouched by normal write");

        // R3 redirected placement, all alternate codes
        for (int a = 0; a < 32; a++) begin
            logic [DW-1:0] d;
            d = DW'(a * 53 + 1000);
            cfg_set_alt(5'(a));
            ovr_en = 1;
            conv(5'((a + 7) % 32), d);
            ovr_en = 0;
            if (a < NS) exp_mem[a] = d;
        end
        sweep_read("R3 slot by alternate");

        // R7 index load sweep, and priority over read
        for (int v = 0; v < 32; v++) begin
            load_idx(5'(v));
            chk(rd_idx == ((v >= NS) ? 5'd0 : 5'(v)), "R7 index load", int'(rd_idx), (v >= NS) ? 0 : v);
        end
        idx_load = 1; idx_val = 5'd4; port_rd = 1;
        tick();
        idx_load = 0; port_rd = 0;
        chk(rd_idx == 4, "R7 load beats read", int'(rd_idx), 4);

        // R8 end of sequence and interrupt gating
        seq_end = 1;
        tick();
        seq_end = 0;
        chk(data_flag == 1, "R8 flag on seq_end", int'(data_flag), 1);
        chk(irq == 0, "R8 irq masked", int'(irq), 0);
        int_en = 1; #0.1;
        chk(irq == 1, "R8 irq enabled", int'(irq), 1);
        pulse_clr();
        chk(data_flag == 0, "R10 clear", int'(data_flag), 0);
        chk(irq == 0, "R8 irq follows flag", int'(irq), 0);

        // R10 set beats clear
        seq_end = 1; flag_clr = 1;
        tick();
        seq_end = 0; flag_clr = 0;
        chk(data_flag == 1, "R10 set wins", int'(data_flag), 1);
        pulse_clr();

        // R9 count trigger sweep
        cnt_mode = 1;
        for (int n = 0; n < 5; n++) begin
            num_smp = CW'(n);
            seq_start = 1;
            tick();
            seq_start = 0;
            for (int rep = 0; rep < 2; rep++) begin
                for (int k = 1; k <= n + 1; k++) begin
                    conv(5'd2, DW'(k));
                    chk(data_flag == ((k == n + 1) ? 1'b1 : 1'b0), "R9 count trigger",
                        int'(data_flag), (k == n + 1) ? 1 : 0);
                end
                pulse_clr();
            end
        end

        // R11 conversion with seq_start is not counted
        num_smp = 5'd1;
        conv(5'd2, 12'd1);
        seq_start = 1; conv_valid = 1;
        tick();
        seq_start = 0; conv_valid = 0;
        conv(5'd2, 12'd1);
        chk(data_flag == 0, "R11 start conversion not counted", int'(data_flag), 0);
        conv(5'd2, 12'd1);
        chk(data_flag == 1, "R11 count from start", int'(data_flag), 1);
        pulse_clr();

        // R9 count mode off
        cnt_mode = 0;
        seq_start = 1;
        tick();
        seq_start = 0;
        for (int k = 0; k < 10; k++) conv(5'd2, 12'd5);
        chk(data_flag == 0, "R9 no count trigger in mode 0", int'(data_flag), 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule